// File: doc/BRIEF.md
# YCbCr to RGB Matrix Converter

This block sits in a display pixel pipeline and converts full-range YCbCr pixels to RGB. Each output colour is the dot product of one row of a programmable 3x3 matrix with the input vector. Coefficients are signed fixed point with twelve fraction bits, so 4096 is a gain of exactly one. Before the multiply, each input component is clamped to its own programmable window, and a programmable input offset is then added. After the multiply, a per-channel output offset is added. The result is rounded, shifted down and saturated to the unsigned 10-bit output range. Pixels tagged as RGB skip the arithmetic and are forwarded unchanged.

Software loads coefficients, offsets and clamp limits through a simple write port into a shadow bank. The shadow bank is copied into the working bank only on a frame strobe, so a frame is never converted with a mix of old and new settings. The datapath is a fixed three-stage pipeline, and the valid and format tags travel with the data.

Top module: `ycc2rgb_matrix`

## Requirements
- R1: After reset, out_valid is 0 and all outputs are 0. With every working setting at zero, a YCbCr pixel produces R=G=B=0.
- R2: Let x_cr, x_y and x_cb be the conditioned inputs. Then R = c0*x_cr + c1*x_y + c2*x_cb, G = c3*x_cr + c4*x_y + c5*x_cb and B = c6*x_cr + c7*x_y + c8*x_cb. Coefficients are signed 16-bit values with 12 fraction bits.
- R3: Each input lane (Y, Cb, Cr) is read as an 11-bit two's complement value. A value above the lane's max is replaced by max; otherwise a value below its min is replaced by min.
- R4: After the clamp, the lane's signed input offset is added. The output offset is added in whole output units before rounding: the Y register's offset goes to G, the Cb register's to B and the Cr register's to R.
- R5: The sum plus 2048 is shifted arithmetically right by 12, so halves round upward. The result is then saturated to 0..1023.
- R6: A pixel with in_is_rgb=1 leaves as out_r=in_cr[9:0], out_g=in_y[9:0] and out_b=in_cb[9:0], with out_is_rgb=1. This holds whatever the settings are.
- R7: A pixel accepted at a clock edge appears on the outputs after exactly three clock edges, with out_valid high for one cycle per input pixel. While out_valid is low, the output data hold their values.
- R8: Write-port address map. Addresses 0 to 3 hold coefficient pairs: address k carries c(2k) in bits 15:0 and c(2k+1) in bits 31:16. Address 4 carries c8 in bits 15:0, and its upper half is ignored. Addresses 5, 6 and 7 (Y, Cb, Cr) carry the input offset in bits 15:0 and the output offset in bits 31:16. Addresses 8, 9 and 10 (Y, Cb, Cr) carry the clamp min in bits 15:0 and the clamp max in bits 31:16. Writes to addresses 11 to 15 have no effect.
- R9: Writes change only the shadow bank. A cycle with frame_start high copies the shadow bank into the working bank. A write in that same cycle reaches the shadow bank only.
- R10: Loading the rows (5743,4096,0), (-2925,4096,-1410), (0,4096,7258) or (6450,4096,0), (-1917,4096,-767), (0,4096,7601) gives exact results for these standard conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Frame boundary; commits the shadow bank |
| in_valid | input | 1 | Input pixel valid |
| in_is_rgb | input | 1 | Input pixel is already RGB |
| in_cr | input | 11 | Cr (signed) or R |
| in_y | input | 11 | Y or G |
| in_cb | input | 11 | Cb (signed) or B |
| out_valid | output | 1 | Output pixel valid |
| out_is_rgb | output | 1 | Format flag of the output pixel |
| out_r | output | 10 | Red |
| out_g | output | 10 | Green |
| out_b | output | 10 | Blue |

## Verification
The properties assume that in_valid stays low during reset and for the first two clock edges after rst_n rises, because the internal reset is still being released then. The stimulus holds every pixel input idle over that window. The format and valid tags are assumed to be sampled cleanly at the clock. The bench meets this by driving everything on the falling edge. The bench asserts frame_start only while no pixel is in flight, so each pixel is converted under a single settings bank.

// File: rtl/ycc_csc_pkg.sv
package ycc_csc_pkg;
  localparam int unsigned N_REGS  = 11;
  localparam int unsigned A_COEF0 = 0;
  localparam int unsigned A_OFS0  = 5;
  localparam int unsigned A_CLMP0 = 8;
  localparam int unsigned N_LANE  = 3;
  localparam int unsigned N_COEF  = 9;
  localparam int unsigned LN_Y    = 0;
  localparam int unsigned LN_CB   = 1;
  localparam int unsigned LN_CR   = 2;
endpackage

// File: rtl/ycc_csc_regs.sv
module ycc_csc_regs #(
  parameter int unsigned AW = 4,
  parameter int unsigned RW = 32,
  parameter int unsigned NR = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [RW-1:0]    wr_data,
  input  logic             commit,
  output logic [NR*RW-1:0] act_flat
);
  logic [RW-1:0] shad_q [NR];
  logic [RW-1:0] shad_d [NR];
  logic [RW-1:0] act_q  [NR];
  logic [RW-1:0] act_d  [NR];

  always_comb begin
    for (int i = 0; i < NR; i++) begin
      shad_d[i] = shad_q[i];
      if (wr_en && (wr_addr == AW'(i))) shad_d[i] = wr_data;
      act_d[i] = commit ? shad_q[i] : act_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) begin
        shad_q[i] <= '0;
        act_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NR; i++) begin
        shad_q[i] <= shad_d[i];
        act_q[i]  <= act_d[i];
      end
    end
  end

  for (genvar g = 0; g < NR; g++) begin : g_flat
    assign act_flat[g*RW +: RW] = act_q[g];
  end
endmodule

// File: rtl/ycc_csc_lane.sv
module ycc_csc_lane #(
  parameter int unsigned IW = 11,
  parameter int unsigned CW = 16,
  parameter int unsigned XW = CW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [IW-1:0] din,
  input  logic signed [CW-1:0] cmin,
  input  logic signed [CW-1:0] cmax,
  input  logic signed [CW-1:0] ioff,
  output logic signed [XW-1:0] x_q
);
  logic signed [CW-1:0] v_ext;
  logic signed [CW-1:0] v_clmp;
  logic signed [XW-1:0] x_d;

  always_comb begin
    v_ext = {{(CW-IW){din[IW-1]}}, din};
    if (v_ext > cmax)      v_clmp = cmax;
    else if (v_ext < cmin) v_clmp = cmin;
    else                   v_clmp = v_ext;
    x_d = XW'(v_clmp) + XW'(ioff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  x_q <= '0;
    else if (en) x_q <= x_d;
  end
endmodule

// File: rtl/ycc_csc_row.sv
module ycc_csc_row #(
  parameter int unsigned CW   = 16,
  parameter int unsigned XW   = CW + 1,
  parameter int unsigned DW   = 10,
  parameter int unsigned FRAC = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [XW-1:0] x_cr,
  input  logic signed [XW-1:0] x_y,
  input  logic signed [XW-1:0] x_cb,
  input  logic signed [CW-1:0] k0,
  input  logic signed [CW-1:0] k1,
  input  logic signed [CW-1:0] k2,
  input  logic signed [CW-1:0] ooff,
  output logic [DW-1:0]        res
);
  localparam int unsigned PW = CW + XW;
  localparam int unsigned SW = PW + 2;
  localparam logic signed [SW-1:0] MAXV = SW'((1 << DW) - 1);

  logic signed [PW-1:0] p_q [3];
  logic signed [PW-1:0] p_d [3];
  logic signed [SW-1:0] acc;
  logic signed [SW-1:0] shd;

  always_comb begin
    p_d[0] = PW'(x_cr) * PW'(k0);
    p_d[1] = PW'(x_y)  * PW'(k1);
    p_d[2] = PW'(x_cb) * PW'(k2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) p_q[i] <= '0;
    end else if (en) begin
      for (int i = 0; i < 3; i++) p_q[i] <= p_d[i];
    end
  end

  always_comb begin
    acc = SW'(p_q[0]) + SW'(p_q[1]) + SW'(p_q[2])
        + (SW'(ooff) <<< FRAC) + (SW'(1) <<< (FRAC - 1));
    shd = acc >>> FRAC;
    if (shd < 0)         res = '0;
    else if (shd > MAXV) res = '1;
    else                 res = shd[DW-1:0];
  end
endmodule

// File: rtl/ycc2rgb_matrix.sv
module ycc2rgb_matrix
  import ycc_csc_pkg::*;
#(
  parameter int unsigned DW   = 10,
  parameter int unsigned CW   = 16,
  parameter int unsigned FRAC = 12,
  parameter int unsigned AW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [2*CW-1:0]   cfg_wdata,
  input  logic              frame_start,
  input  logic              in_valid,
  input  logic              in_is_rgb,
  input  logic [DW:0]       in_cr,
  input  logic [DW:0]       in_y,
  input  logic [DW:0]       in_cb,
  output logic              out_valid,
  output logic              out_is_rgb,
  output logic [DW-1:0]     out_r,
  output logic [DW-1:0]     out_g,
  output logic [DW-1:0]     out_b
);
  localparam int unsigned IW = DW + 1;
  localparam int unsigned XW = CW + 1;
  localparam int unsigned RW = 2 * CW;
  localparam int unsigned PXW = 3 * DW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // settings banks
  logic [N_REGS*RW-1:0] act_flat;
  ycc_csc_regs #(.AW(AW), .RW(RW), .NR(N_REGS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_i),
    .wr_en    (cfg_wr),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_wdata),
    .commit   (frame_start),
    .act_flat (act_flat)
  );

  logic signed [CW-1:0] coef [N_COEF];
  logic signed [CW-1:0] cmin [N_LANE];
  logic signed [CW-1:0] cmax [N_LANE];
  logic signed [CW-1:0] ioff [N_LANE];
  logic signed [CW-1:0] ooff [N_LANE];
  logic                 unused_c8_hi;

  for (genvar g = 0; g < N_COEF; g++) begin : g_coef
    assign coef[g] = act_flat[(A_COEF0 + g/2)*RW + (g%2)*CW +: CW];
  end
  assign unused_c8_hi = ^act_flat[(A_COEF0 + N_COEF/2)*RW + CW +: CW];

  for (genvar l = 0; l < N_LANE; l++) begin : g_lcfg
    assign ioff[l] = act_flat[(A_OFS0 + l)*RW      +: CW];
    assign ooff[l] = act_flat[(A_OFS0 + l)*RW + CW +: CW];
    assign cmin[l] = act_flat[(A_CLMP0 + l)*RW      +: CW];
    assign cmax[l] = act_flat[(A_CLMP0 + l)*RW + CW +: CW];
  end

  // stage 1: clamp and input offset
  logic [IW-1:0]        din [N_LANE];
  logic signed [XW-1:0] xv  [N_LANE];
  assign din[LN_Y]  = in_y;
  assign din[LN_CB] = in_cb;
  assign din[LN_CR] = in_cr;

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    ycc_csc_lane #(.IW(IW), .CW(CW), .XW(XW)) u_lane (
      .clk   (clk),
      .rst_n (rst_i),
      .en    (in_valid),
      .din   (din[l]),
      .cmin  (cmin[l]),
      .cmax  (cmax[l]),
      .ioff  (ioff[l]),
      .x_q   (xv[l])
    );
  end

  // valid, flag and bypass tracks
  logic [1:0]     v_q, v_d;
  logic [1:0]     f_q, f_d;
  logic [PXW-1:0] b1_q, b1_d, b2_q, b2_d;
  logic [PXW-1:0] pix_raw;

  assign pix_raw = {in_cr[DW-1:0], in_y[DW-1:0], in_cb[DW-1:0]};

  always_comb begin
    v_d  = {v_q[0], in_valid};
    f_d  = f_q;
    b1_d = b1_q;
    b2_d = b2_q;
    if (in_valid) begin
      f_d[0] = in_is_rgb;
      b1_d   = pix_raw;
    end
    if (v_q[0]) begin
      f_d[1] = f_q[0];
      b2_d   = b1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      v_q  <= '0;
      f_q  <= '0;
      b1_q <= '0;
      b2_q <= '0;
    end else begin
      v_q  <= v_d;
      f_q  <= f_d;
      b1_q <= b1_d;
      b2_q <= b2_d;
    end
  end

  // stages 2 and 3: products, sum, round, saturate
  logic [DW-1:0] row_res [3];
  for (genvar g = 0; g < 3; g++) begin : g_row
    localparam int unsigned OL = (g == 0) ? LN_CR : ((g == 1) ? LN_Y : LN_CB);
    ycc_csc_row #(.CW(CW), .XW(XW), .DW(DW), .FRAC(FRAC)) u_row (
      .clk   (clk),
      .rst_n (rst_i),
      .en    (v_q[0]),
      .x_cr  (xv[LN_CR]),
      .x_y   (xv[LN_Y]),
      .x_cb  (xv[LN_CB]),
      .k0    (coef[3*g]),
      .k1    (coef[3*g+1]),
      .k2    (coef[3*g+2]),
      .ooff  (ooff[OL]),
      .res   (row_res[g])
    );
  end

  // output register
  logic [PXW-1:0] o_d;
  logic           of_d;
  always_comb begin
    o_d  = {out_r, out_g, out_b};
    of_d = out_is_rgb;
    if (v_q[1]) begin
      of_d = f_q[1];
      o_d  = f_q[1] ? b2_q : {row_res[0], row_res[1], row_res[2]};
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      out_valid  <= 1'b0;
      out_is_rgb <= 1'b0;
      {out_r, out_g, out_b} <= '0;
    end else begin
      out_valid  <= v_q[1];
      out_is_rgb <= of_d;
      {out_r, out_g, out_b} <= o_d;
    end
  end
endmodule

// File: rtl/ycc2rgb_matrix_chk.sv
module ycc2rgb_matrix_chk #(
  parameter int unsigned DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_is_rgb,
  input logic [DW:0]   in_cr,
  input logic [DW:0]   in_y,
  input logic [DW:0]   in_cb,
  input logic          out_valid,
  input logic          out_is_rgb,
  input logic [DW-1:0] out_r,
  input logic [DW-1:0] out_g,
  input logic [DW-1:0] out_b
);
  logic [2:0] since_q;
  logic       warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_q <= '0;
    else if (since_q != 3'd4) since_q <= since_q + 3'd1;
  end
  assign warm = (since_q == 3'd4);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q < 3'd3) |-> !out_valid);

  a_r7_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 3)));

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_r) && $stable(out_g) && $stable(out_b)));

  a_r6_flag_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid) |-> (out_is_rgb == $past(in_is_rgb, 3)));

  a_r6_rgb_pass_r: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && out_is_rgb) |-> (out_r == $past(in_cr[DW-1:0], 3)));

  a_r6_rgb_pass_gb: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && out_is_rgb) |->
      ((out_g == $past(in_y[DW-1:0], 3)) && (out_b == $past(in_cb[DW-1:0], 3))));
endmodule

bind ycc2rgb_matrix ycc2rgb_matrix_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_is_rgb  (in_is_rgb),
  .in_cr      (in_cr),
  .in_y       (in_y),
  .in_cb      (in_cb),
  .out_valid  (out_valid),
  .out_is_rgb (out_is_rgb),
  .out_r      (out_r),
  .out_g      (out_g),
  .out_b      (out_b)
);

// File: tb/ycc2rgb_matrix_tb.sv
module ycc2rgb_matrix_tb;
  localparam int CLK_P = 10;
  localparam int DW = 10;
  localparam int NV = 12;

  typedef struct packed {
    logic              rgb;
    logic signed [10:0] cr;
    logic signed [10:0] y;
    logic signed [10:0] cb;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{1'b0,  11'sd0,   11'sd512,  11'sd0},
    '{1'b0,  11'sd0,   11'sd0,    11'sd0},
    '{1'b0,  11'sd0,   11'sd1023, 11'sd0},
    '{1'b0,  11'sd200, 11'sd600,  -11'sd150},
    '{1'b0, -11'sd300, 11'sd400,  11'sd250},
    '{1'b0,  11'sd512, 11'sd1023, 11'sd512},
    '{1'b0, -11'sd512, 11'sd100,  -11'sd512},
    '{1'b0,  11'sd700, 11'sd300,  -11'sd700},
    '{1'b1,  11'sd341, 11'sd77,   11'sd1000},
    '{1'b1, -11'sd1,   11'sd0,    11'sd513},
    '{1'b0,  11'sd100, -11'sd20,  11'sd30},
    '{1'b0, -11'sd64,  11'sd64,   11'sd64}
  };

  logic clk, rst_n, cfg_wr, frame_start, in_valid, in_is_rgb;
  logic [3:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic [10:0] in_cr, in_y, in_cb;
  logic out_valid, out_is_rgb;
  logic [9:0] out_r, out_g, out_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int p_c [9], p_ioff [3], p_ooff [3], p_min [3], p_max [3];
  int a_c [9], a_ioff [3], a_ooff [3], a_min [3], a_max [3];

  ycc2rgb_matrix u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start), .in_valid(in_valid),
    .in_is_rgb(in_is_rgb), .in_cr(in_cr), .in_y(in_y), .in_cb(in_cb),
    .out_valid(out_valid), .out_is_rgb(out_is_rgb),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic int s16(logic [15:0] v);
    return int'($signed(v));
  endfunction

  function automatic logic [31:0] pk(int hi, int lo);
    logic [15:0] h = 16'(hi);
    logic [15:0] l = 16'(lo);
    return {h, l};
  endfunction

  function automatic int sx11(int v);
    logic [10:0] t = 11'(v);
    return int'($signed(t));
  endfunction

  function automatic int clampv(int v, int mn, int mx);
    if (v > mx) return mx;
    if (v < mn) return mn;
    return v;
  endfunction

  function automatic logic [9:0] finish_row(longint acc);
    longint s = (acc + 2048) >>> 12;
    if (s < 0) return 10'd0;
    if (s > 1023) return 10'd1023;
    return 10'(s);
  endfunction

  // expected {r,g,b} from the working-bank model
  function automatic logic [29:0] expect_px(bit rgb, int cr, int y, int cb);
    logic [10:0] tr = 11'(cr);
    logic [10:0] tg = 11'(y);
    logic [10:0] tb = 11'(cb);
    longint xy, xb, xr;
    if (rgb) return {tr[9:0], tg[9:0], tb[9:0]};
    xy = longint'(clampv(sx11(y),  a_min[0], a_max[0]) + a_ioff[0]);
    xb = longint'(clampv(sx11(cb), a_min[1], a_max[1]) + a_ioff[1]);
    xr = longint'(clampv(sx11(cr), a_min[2], a_max[2]) + a_ioff[2]);
    return {finish_row(a_c[0]*xr + a_c[1]*xy + a_c[2]*xb + longint'(a_ooff[2])*4096),
            finish_row(a_c[3]*xr + a_c[4]*xy + a_c[5]*xb + longint'(a_ooff[0])*4096),
            finish_row(a_c[6]*xr + a_c[7]*xy + a_c[8]*xb + longint'(a_ooff[1])*4096)};
  endfunction

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic note_wr(int a, logic [31:0] d);
    if (a < 5) begin
      p_c[2*a] = s16(d[15:0]);
      if (a < 4) p_c[2*a+1] = s16(d[31:16]);
    end else if (a < 8) begin
      p_ioff[a-5] = s16(d[15:0]);
      p_ooff[a-5] = s16(d[31:16]);
    end else if (a < 11) begin
      p_min[a-8] = s16(d[15:0]);
      p_max[a-8] = s16(d[31:16]);
    end
  endtask

  task automatic take_pend();
    a_c = p_c; a_ioff = p_ioff; a_ooff = p_ooff; a_min = p_min; a_max = p_max;
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    note_wr(a, d);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    frame_start = 1'b1;
    take_pend();
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic wr_commit(int a, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 4'(a); cfg_wdata = d; frame_start = 1'b1;
    take_pend();
    note_wr(a, d);
    @(negedge clk);
    cfg_wr = 1'b0; frame_start = 1'b0;
  endtask

  task automatic px(string req, bit rgb, int cr, int y, int cb, logic [29:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_is_rgb = rgb;
    in_cr = 11'(cr); in_y = 11'(y); in_cb = 11'(cb);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk({req, " R7 early"}, int'(out_valid), 0);
    @(negedge clk);
    chk({req, " R7 valid"}, int'(out_valid), 1);
    chk({req, " R6 flag"}, int'(out_is_rgb), int'(rgb));
    chk(req, int'({out_r, out_g, out_b}), int'(exp));
  endtask

  task automatic run_table(string req);
    logic [29:0] exq [NV];
    for (int k = 0; k < NV + 3; k++) begin
      @(negedge clk);
      if (k >= 3) begin
        chk({req, " R7 stream valid"}, int'(out_valid), 1);
        chk(req, int'({out_r, out_g, out_b}), int'(exq[k-3]));
      end
      if (k < NV) begin
        in_valid = 1'b1; in_is_rgb = TBL[k].rgb;
        in_cr = TBL[k].cr; in_y = TBL[k].y; in_cb = TBL[k].cb;
        exq[k] = expect_px(TBL[k].rgb, int'(TBL[k].cr), int'(TBL[k].y), int'(TBL[k].cb));
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 9; i++) p_c[i] = 0;
    for (int i = 0; i < 3; i++) begin
      p_ioff[i] = 0; p_ooff[i] = 0; p_min[i] = 0; p_max[i] = 0;
    end
    take_pend();
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    frame_start = 1'b0; in_valid = 1'b0; in_is_rgb = 1'b0;
    in_cr = '0; in_y = '0; in_cb = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(out_valid), 0);
    chk("R1 reset data", int'({out_r, out_g, out_b}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: zeroed settings give black; R6: RGB passes regardless
    px("R1 zero cfg", 1'b0, 300, 700, -200, 30'd0);
    px("R6 zero cfg rgb", 1'b1, 5, 6, 7, {10'd5, 10'd6, 10'd7});

    // R9: writes are invisible until the frame strobe
    wr(0, pk(4096, 5743)); wr(1, pk(-2925, 0)); wr(2, pk(-1410, 4096));
    wr(3, pk(4096, 0));    wr(4, pk(0, 7258));
    wr(8, pk(1023, 0));    wr(9, pk(512, -512)); wr(10, pk(512, -512));
    px("R9 before commit", 1'b0, 0, 512, 0, 30'd0);
    commit();

    // R10/R2: standard matrix 1
    px("R10 601 grey", 1'b0, 0, 512, 0, {10'd512, 10'd512, 10'd512});
    run_table("R10 R2 R5 table 601");

    // R10: standard matrix 2
    wr(0, pk(4096, 6450)); wr(1, pk(-1917, 0)); wr(2, pk(-767, 4096));
    wr(3, pk(4096, 0));    wr(4, pk(0, 7601));
    commit();
    px("R10 709 grey", 1'b0, 0, 512, 0, {10'd512, 10'd512, 10'd512});
    run_table("R10 R2 table 709");

    // R8/R2: permuted unit matrix, junk in the unused half of address 4
    wr(0, pk(4096, 0)); wr(1, pk(4096, 0)); wr(2, 32'd0); wr(3, 32'd0);
    wr(4, 32'hFFFF_1000);
    commit();
    px("R8 R2 row order", 1'b0, 100, 200, 300, {10'd200, 10'd100, 10'd300});
    wr(11, 32'hDEAD_BEEF); wr(15, 32'h1234_5678);
    commit();
    px("R8 unmapped addr", 1'b0, 100, 200, 300, {10'd200, 10'd100, 10'd300});

    // R3: clamps
    wr(8, pk(200, 100)); wr(10, pk(50, 10));
    commit();
    px("R3 clamp low", 1'b0, 80, 50, 300, {10'd100, 10'd50, 10'd300});
    px("R3 clamp high", 1'b0, 0, 250, -20, {10'd200, 10'd10, 10'd0});

    // R4: offsets
    wr(5, pk(-7, 30)); wr(7, pk(5, 0));
    commit();
    px("R4 offsets", 1'b0, 40, 150, 300, {10'd185, 10'd33, 10'd300});

    // R5: rounding and saturation
    wr(5, 32'd0); wr(7, 32'd0); wr(8, pk(1023, 0)); wr(10, pk(512, -512));
    wr(0, pk(2048, 0));
    commit();
    px("R5 half up 1", 1'b0, 0, 1, 0, {10'd1, 10'd0, 10'd0});
    px("R5 half up 3", 1'b0, 0, 3, 0, {10'd2, 10'd0, 10'd0});
    px("R5 model", 1'b0, 0, 2, 0, expect_px(1'b0, 0, 2, 0));
    wr(0, pk(32767, 0));
    commit();
    px("R5 sat high", 1'b0, 0, 200, 0, {10'd1023, 10'd0, 10'd0});
    wr(0, pk(-2048, 0)); wr(7, pk(1, 0));
    commit();
    px("R5 neg half", 1'b0, 0, 1, 0, {10'd1, 10'd0, 10'd0});
    px("R5 sat low", 1'b0, 0, 5, 0, 30'd0);

    // R9: pending write, then write in the commit cycle
    wr(0, pk(1024, 0));
    px("R9 pending", 1'b0, 0, 1, 0, {10'd1, 10'd0, 10'd0});
    wr_commit(0, pk(4096, 0));
    px("R9 same cycle", 1'b0, 0, 8, 0, {10'd3, 10'd0, 10'd0});
    commit();
    px("R9 next commit", 1'b0, 0, 8, 0, {10'd9, 10'd0, 10'd0});

    // R7: outputs hold while idle
    repeat (4) @(negedge clk);
    chk("R7 idle valid", int'(out_valid), 0);
    chk("R7 idle hold", int'({out_r, out_g, out_b}), int'({10'd9, 10'd0, 10'd0}));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule